// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of an 8192-byte serial memory. It watches the two-wire clock and data lines with a fast system clock and finds start and stop conditions. It shifts bytes in and out with the most significant bit first, and answers on the data line through an active-low pull-down enable. The first byte after a start selects the device: a fixed 4-bit family code, three select bits that must match the strap pins, and a direction bit. A write command is followed by two address bytes and then by any number of data bytes. Each data byte is handed to an external page programmer as a one-cycle strobe.

A stop that closes a write with at least one data byte asks the programmer to commit. While the programmer reports busy, command bytes get no acknowledge, so a host can poll until programming ends. Reads take their bytes from a combinational memory port addressed by the internal counter. A random read is a write command with an address, then a repeated start and a read command. A current-address read skips the address phase. A sequential read runs as long as the host acknowledges each byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A start (data falling while clock is high) aborts any transfer in progress, including a partly received byte, and the next 8 bits are treated as a command byte; no data strobe is produced for the aborted byte.
- R2: A command byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `cs_pins`; bit 0 selects read (1) or write (0). A non-matching command is not acknowledged, and later bytes are ignored until the next start.
- R3: The slave pulls data low (`sda_oe_n`=0) during the 9th clock of every byte it accepts, and it changes its drive only while the clock is low.
- R4: After a write command, the low 5 bits of the first address byte become address bits 12..8 and its upper 3 bits are ignored; the second byte gives bits 7..0. Both address bytes are acknowledged.
- R5: Read bytes are `rd_data` at the counter, sent MSB first. The counter advances by one after each byte and wraps from 8191 to 0. Reading continues while the host acknowledges and ends on a missing acknowledge.
- R6: Each write data byte is acknowledged and strobed on `wr_valid` for one cycle with `wr_addr` and `wr_data`. Afterwards only address bits 4..0 advance, wrapping inside the 32-byte page.
- R7: While `busy` is high, no command byte is acknowledged.
- R8: A stop after one or more write data bytes pulses `wr_commit` once. A stop with no data bytes does not pulse it, and a repeated start drops the pending write without a commit.
- R9: A read command with no address phase starts at the counter value left by the previous transfer.
- R10: After reset the data line is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |
| cs_pins | input | 3 | Strap pins compared with command bits 3..1 |
| busy | input | 1 | Programmer busy; blocks command acknowledge |
| rd_addr | output | 13 | Current address counter, memory read address |
| rd_data | input | 8 | Memory byte at `rd_addr` |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 13 | Address of the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_commit | output | 1 | One-cycle request to program the collected page |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a data byte, after the address phase has armed a write. The bench clocks out only three bits of a data byte and then issues a start followed by a read command. No write strobe may appear, and the byte read back must come from the address that was just set. Both the counter wrap at 8191 and the page wrap on writes are reached by placing the start address a few bytes below the boundary. Every command code for all select and direction values is swept against fixed strap pins.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_n,
  input  logic [2:0]        cs_pins,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [PAGE_W-1:0] P_ONE = 1;
  localparam logic [2:0] ST_IDLE = 3'd0, ST_CMD = 3'd1, ST_AHI = 3'd2,
                         ST_ALO = 3'd3, ST_WR = 3'd4, ST_RD = 3'd5;

  logic [2:0] scl_sy, sda_sy;
  logic [2:0] state;
  logic [3:0] bitcnt;
  logic [6:0] sr;
  logic [7:0] rdbyte;
  logic [HI_W-1:0] ahi;
  logic [ADDR_W-1:0] addr;
  logic pull, ack_pend, wdone;

  wire scl_s = scl_sy[1], scl_q = scl_sy[2];
  wire sda_s = sda_sy[1], sda_q = sda_sy[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_in = {sr, sda_s};
  wire cmd_ok = (byte_in[7:4] == DEV_ID) && (byte_in[3:1] == cs_pins) && !busy;

  assign sda_oe_n = ~pull;
  assign rd_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; sr <= '0; rdbyte <= '0; ahi <= '0;
      addr <= '0; pull <= 1'b0; ack_pend <= 1'b0; wdone <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_ev) begin
        state <= ST_CMD; bitcnt <= '0; pull <= 1'b0; ack_pend <= 1'b0; wdone <= 1'b0;
      end else if (stop_ev) begin
        state <= ST_IDLE; bitcnt <= '0; pull <= 1'b0; ack_pend <= 1'b0;
        wr_commit <= wdone; wdone <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt != 4'd8) begin
            sr     <= byte_in[6:0];
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              case (state)
                ST_CMD: begin
                  ack_pend <= cmd_ok;
                  state    <= !cmd_ok ? ST_IDLE : (byte_in[0] ? ST_RD : ST_AHI);
                end
                ST_AHI: begin
                  ahi <= byte_in[HI_W-1:0]; ack_pend <= 1'b1; state <= ST_ALO;
                end
                ST_ALO: begin
                  addr <= {ahi, byte_in}; ack_pend <= 1'b1; state <= ST_WR;
                end
                ST_WR: begin
                  wr_valid <= 1'b1; wr_addr <= addr; wr_data <= byte_in;
                  addr     <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + P_ONE};
                  wdone    <= 1'b1; ack_pend <= 1'b1;
                end
                default: ack_pend <= 1'b0;
              endcase
            end
          end else begin
            bitcnt   <= '0;
            ack_pend <= 1'b0;
            if (state == ST_RD) begin
              if (!sda_s) begin
                rdbyte <= rd_data;
                addr   <= addr + A_ONE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8)     pull <= ack_pend;
          else if (state == ST_RD) pull <= ~rdbyte[3'd7 - bitcnt[2:0]];
          else                     pull <= 1'b0;
        end
      end
    end
  end
endmodule

module i2c_eeprom_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_ev,
  input logic              sda_oe_n,
  input logic              busy,
  input logic [2:0]        state,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid
);
  localparam logic [2:0] C_CMD = 3'd1, C_AHI = 3'd2, C_RD = 3'd5;
  localparam logic [ADDR_W-1:0] C_ONE = 1;

  assert_release_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> sda_oe_n);

  assert_drive_on_low_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_n) |-> !scl_s);

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_RD && $past(state) == C_RD && rd_addr != $past(rd_addr))
      |-> rd_addr == $past(rd_addr) + C_ONE);

  assert_one_cycle_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_no_cmd_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_AHI && $past(state) == C_CMD) |-> !$past(busy));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev), .sda_oe_n(sda_oe_n),
  .busy(busy), .state(state), .rd_addr(rd_addr), .wr_valid(wr_valid)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, busy = 1'b0;
  logic [2:0] cs = 3'b101;
  logic sda_oe_n, wr_valid, wr_commit, sda_bus;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  function automatic logic [7:0] memf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction

  assign sda_bus = sda_h & sda_oe_n;
  assign rd_data = memf(rd_addr);

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_n(sda_oe_n),
    .cs_pins(cs), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vec = 0, bad = 0, wn = 0, ncommit = 0;
  logic [12:0] wa [0:15];
  logic [7:0]  wd [0:15];

  always @(posedge clk) begin
    if (wr_valid && wn < 16) begin
      wa[wn] <= wr_addr;
      wd[wn] <= wr_data;
    end
    if (wr_valid) wn <= wn + 1;
    if (wr_commit) ncommit <= ncommit + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wt(H); scl = 1'b1; wt(H); sda_h = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wt(H); scl = 1'b1; wt(H); sda_h = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(H);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_h = 1'b1; wt(H); scl = 1'b1; wt(H/2);
    ack = !sda_bus;
    wt(H/2); scl = 1'b0; wt(H);
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(H/2);
      b[i] = sda_bus;
      wt(H/2); scl = 1'b0; wt(H);
    end
    sda_h = host_ack ? 1'b0 : 1'b1;
    wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(H);
    sda_h = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    wt(4);
    check("R10 reset drive", sda_oe_n, 1);
    check("R10 reset strobe", wr_valid | wr_commit, 0);
    rst_n = 1'b1;
    wt(4);

    // R2: sweep every select and direction value against pins 101
    for (int c = 0; c < 8; c++) begin
      for (int rw = 0; rw < 2; rw++) begin
        bus_start();
        send_byte({4'b1010, c[2:0], rw[0]}, ack);
        check($sformatf("R2 cmd sel=%0d rw=%0d ack", c, rw), ack, (c == 5) ? 1 : 0);
        if (ack && rw == 1) read_byte(1'b0, b);
        bus_stop();
      end
    end
    bus_start();
    send_byte(8'hBA, ack);
    check("R2 wrong family code ack", ack, 0);
    send_byte(8'hAA, ack);
    check("R2 byte after mismatch ignored", ack, 0);
    bus_stop();

    // R7: busy blocks the command acknowledge
    busy = 1'b1;
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    check("R7 busy command ack", ack, 0);
    busy = 1'b0;
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    check("R7 idle command ack", ack, 1);
    wt(4);
    check("R8 no commit without data", ncommit, 0);

    // R4 R6 R8: page write across page end
    bus_start();
    send_byte(8'hAA, ack); check("R3 cmd ack in 9th clock", ack, 1);
    send_byte(8'h1F, ack); check("R4 addr hi ack", ack, 1);
    send_byte(8'hFE, ack); check("R4 addr lo ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h3C + 8'(k * 37), ack);
      check($sformatf("R6 data byte %0d ack", k), ack, 1);
    end
    bus_stop();
    wt(4);
    check("R6 strobe count", wn, 4);
    check("R6 addr 0", wa[0], 13'h1FFE);
    check("R6 addr 1", wa[1], 13'h1FFF);
    check("R6 addr 2 page wrap", wa[2], 13'h1FE0);
    check("R6 addr 3", wa[3], 13'h1FE1);
    for (int k = 0; k < 4; k++)
      check($sformatf("R6 data %0d", k), wd[k], 8'h3C + 8'(k * 37));
    check("R8 commit after write", ncommit, 1);

    // R9: current address read
    bus_start();
    send_byte(8'hAB, ack); check("R9 read cmd ack", ack, 1);
    read_byte(1'b0, b);
    check("R9 current address byte", b, memf(13'h1FE2));
    bus_stop();

    // R5 R8: random then sequential read across array end
    bus_start();
    send_byte(8'hAA, ack); send_byte(8'h1F, ack); send_byte(8'hFC, ack);
    bus_start();
    send_byte(8'hAB, ack); check("R5 random read cmd ack", ack, 1);
    for (int i = 0; i < 40; i++) begin
      read_byte(i != 39, b);
      check($sformatf("R5 seq byte %0d", i), b, memf(13'(13'h1FFC + i)));
    end
    bus_stop();
    wt(4);
    check("R8 repeated start no commit", ncommit, 1);

    // R1 R4: start inside a data byte; upper address bits ignored
    bus_start();
    send_byte(8'hAA, ack); send_byte(8'hE5, ack); send_byte(8'h10, ack);
    send_bits(8'hFF, 3);
    bus_start();
    send_byte(8'hAB, ack); check("R1 command after mid-byte start ack", ack, 1);
    read_byte(1'b0, b);
    check("R4 address hi mask", b, memf(13'h0510));
    bus_stop();
    wt(4);
    check("R1 no strobe from aborted byte", wn, 4);
    check("R1 no commit from aborted byte", ncommit, 1);
    check("R3 line released at end", sda_oe_n, 1);

    summary();
    $finish;
  end
endmodule